// File: doc/BRIEF.md
# EEPROM Status and Write-Permission Unit

This block sits beside the command decoder of a serial EEPROM. It keeps the status byte: a two-bit protect field that fences off part of the array, a write-enable latch, and a busy flag that a write-cycle timer drives. A decoder gives it a one-cycle strobe for each completed command, and with each strobe it gives the target byte address and, for a status write, the data byte. The unit answers on the same cycle. A grant starts the internal write cycle. A deny pulse means the request was dropped.

The write-protect pin acts as a level. While it is low, the latch is held clear and every write is refused. A power-fail pulse cancels any cycle in progress and drops the latch. The write-cycle length is a parameter given in clock cycles. The default value is 4 ms at 5 MHz, and a short value can be used in simulation.

Top module: `eeprom_guard`

## Requirements
- R1: `status` is {4'b1111, prot[1:0], wel, busy}. Bits 7..4 always read 1. After reset `status` is 8'hF0.
- R2: `addr_locked` is high for the addresses the protect field covers. prot=0 covers none. prot=1 covers addresses whose two top bits are both 1 (the top quarter). prot=2 covers addresses whose top bit is 1 (the top half). prot=3 covers the whole array.
- R3: `wel` becomes 1 only on the edge that samples `cmd_wren`, and only while the unit is idle and `wp_n` is high.
- R4: `wel` is cleared at the edge after a `cmd_wrdi` strobe taken while idle. It is also cleared at any edge where `wp_n` is low, and at the edge that ends a write cycle.
- R5: A `cmd_write` or `cmd_wrsr` strobe is refused when `wel` is 0, when `busy` is 1, when `wp_n` is low, or when `pwr_fail` is high. A `cmd_write` strobe is also refused when `addr_locked` is high. A refused strobe raises `deny` in the same cycle and changes no state.
- R6: A granted strobe raises `busy` at the next edge. `busy` then stays high for exactly WIP_CYCLES clock cycles.
- R7: A status write takes only data bits 3:2 as the new protect field. The old field keeps reading back until the write cycle ends, and the new value shows from the first cycle with `busy` low.
- R8: `pwr_fail` clears `busy` and `wel` at the next edge. A status write in flight at that moment is discarded.
- R9: `cmd_wren` and `cmd_wrdi` have no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pwr_fail | input | 1 | Supply-drop pulse |
| wp_n | input | 1 | Write-protect pin level, low protects |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| cmd_write | input | 1 | Memory-write command strobe |
| tgt_addr | input | AW | Target byte address of the memory write |
| sr_wdata | input | 8 | Data byte of the status write |
| status | output | 8 | Status byte |
| addr_locked | output | 1 | `tgt_addr` is inside the protected area |
| grant_mem | output | 1 | Memory write accepted this cycle |
| grant_sr | output | 1 | Status write accepted this cycle |
| deny | output | 1 | Write strobe refused this cycle |

## Verification
Every state bit of the unit appears in the status byte or in the grant outputs on the cycle after it changes. A latch that fails to clear shows up on the next write strobe as a grant where a deny was expected. A wrong timer count shows as a busy flag that falls one cycle early or late. A protect field committed too soon shows on the first status read inside the cycle. The bench sweeps every protect setting against every address of a small array, so a decode slip appears as a wrong grant for that exact address within two cycles.

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
  parameter int AW = 9,
  parameter int WIP_CYCLES = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          wp_n,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_wrsr,
  input  logic          cmd_write,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    sr_wdata,
  output logic [7:0]    status,
  output logic          addr_locked,
  output logic          grant_mem,
  output logic          grant_sr,
  output logic          deny
);
  localparam int CW = $clog2(WIP_CYCLES + 1);

  logic [1:0]    prot, prot_next;
  logic          wel, busy, sr_cycle;
  logic [CW-1:0] left;
  logic          done, may_write;

  wire unused_sr = ^{sr_wdata[7:4], sr_wdata[1:0]};

  always_comb begin
    case (prot)
      2'd0:    addr_locked = 1'b0;
      2'd1:    addr_locked = &tgt_addr[AW-1:AW-2];
      2'd2:    addr_locked = tgt_addr[AW-1];
      default: addr_locked = 1'b1;
    endcase
  end

  assign done      = busy && (left == '0);
  assign may_write = wel && !busy && wp_n && !pwr_fail;
  assign grant_sr  = cmd_wrsr && may_write;
  assign grant_mem = cmd_write && !cmd_wrsr && may_write && !addr_locked;
  assign deny      = (cmd_write || cmd_wrsr) && !(grant_mem || grant_sr);
  assign status    = {4'hF, prot, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sr_cycle <= 1'b0;
      left     <= '0;
    end else if (pwr_fail || done) begin
      busy     <= 1'b0;
      sr_cycle <= 1'b0;
      left     <= '0;
    end else if (grant_mem || grant_sr) begin
      busy     <= 1'b1;
      sr_cycle <= grant_sr;
      left     <= CW'(WIP_CYCLES - 1);
    end else if (busy) begin
      left <= left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot      <= 2'b00;
      prot_next <= 2'b00;
    end else begin
      if (grant_sr) prot_next <= sr_wdata[3:2];
      if (done && sr_cycle && !pwr_fail) prot <= prot_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wel <= 1'b0;
    else if (pwr_fail || done)   wel <= 1'b0;
    else if (!wp_n)              wel <= 1'b0;
    else if (!busy && cmd_wren)  wel <= 1'b1;
    else if (!busy && cmd_wrdi)  wel <= 1'b0;
  end
endmodule

// File: rtl/eeprom_guard_chk.sv
module eeprom_guard_chk #(
  parameter int WIP_CYCLES = 20000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_fail,
  input logic       wp_n,
  input logic       cmd_wren,
  input logic [7:0] status,
  input logic       addr_locked,
  input logic       grant_mem,
  input logic       grant_sr
);
  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run <= 0;
    else if (!status[0]) run <= 0;
    else                 run <= run + 1;
  end

  assert_fixed_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:4] == 4'hF);
  assert_lock_respected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_mem |-> !addr_locked);
  assert_wel_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cmd_wren));
  assert_wp_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !status[1]);
  assert_end_clears_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);
  assert_grant_needs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_mem || grant_sr) |-> (status[1] && !status[0] && wp_n));
  assert_busy_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(grant_mem || grant_sr));
  assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (run < WIP_CYCLES));
  assert_prot_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0])) |-> $stable(status[3:2]));
  assert_pwr_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (status[1:0] == 2'b00));
endmodule

bind eeprom_guard eeprom_guard_chk #(.WIP_CYCLES(WIP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .wp_n(wp_n),
  .cmd_wren(cmd_wren), .status(status), .addr_locked(addr_locked),
  .grant_mem(grant_mem), .grant_sr(grant_sr)
);

// File: tb/eeprom_guard_test.sv
`timescale 1ns/1ps
module eeprom_guard_test;
  localparam int AW = 4;
  localparam int WC = 6;

  logic clk = 0, rst_n = 0, pwr_fail = 0, wp_n = 1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0;
  logic [AW-1:0] tgt_addr = '0;
  logic [7:0] sr_wdata = '0;
  logic [7:0] status;
  logic addr_locked, grant_mem, grant_sr, deny;
  logic gm, gs, dn;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eeprom_guard #(.AW(AW), .WIP_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_write(cmd_write), .tgt_addr(tgt_addr), .sr_wdata(sr_wdata),
    .status(status), .addr_locked(addr_locked), .grant_mem(grant_mem),
    .grant_sr(grant_sr), .deny(deny));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] s, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    {cmd_write, cmd_wrsr, cmd_wren, cmd_wrdi} = s;
    tgt_addr = a; sr_wdata = d;
    #1;
    gm = grant_mem; gs = grant_sr; dn = deny;
    @(negedge clk);
    {cmd_write, cmd_wrsr, cmd_wren, cmd_wrdi} = 4'b0;
  endtask

  function automatic bit lock_of(input int p, input int a);
    return (p == 3) || (p == 2 && a >= 8) || (p == 1 && a >= 12);
  endfunction

  task automatic ride_cycle(input int p, input string req);
    chk(status[0] == 1'b1, req, status[0], 1);
    repeat (WC - 1) begin
      @(negedge clk);
      chk(status[0] == 1'b1, req, status[0], 1);
    end
    @(negedge clk);
    chk(status == {4'hF, 2'(p), 2'b00}, req, status, {4'hF, 2'(p), 2'b00});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cur;
    repeat (3) @(negedge clk);
    chk(status == 8'hF0, "R1 reset", status, 8'hF0);
    rst_n = 1;
    @(negedge clk);
    chk(status == 8'hF0, "R1 idle", status, 8'hF0);

    issue(4'b1000, 4'd0, 8'h00);
    chk(dn && !gm, "R5 no wel", {dn, gm}, 2'b10);
    chk(status == 8'hF0, "R5 no change", status, 8'hF0);

    cur = 0;
    for (int p = 0; p < 4; p++) begin
      issue(4'b0010, 4'd0, 8'h00);
      chk(status[1] == 1'b1, "R3 wren", status[1], 1);
      issue(4'b0100, 4'd0, 8'hF3 | 8'(p << 2));
      chk(gs && !dn, "R5 wrsr grant", gs, 1);
      chk(status[3:2] == 2'(cur), "R7 old prot", status[3:2], cur);
      ride_cycle(p, "R7 R6 R4 wrsr");
      cur = p;
      for (int a = 0; a < 16; a++) begin
        @(negedge clk);
        tgt_addr = 4'(a); #1;
        chk(addr_locked == lock_of(p, a), "R2 decode", addr_locked, lock_of(p, a));
        issue(4'b0010, 4'd0, 8'h00);
        issue(4'b1000, 4'(a), 8'h00);
        if (lock_of(p, a)) begin
          chk(dn && !gm, "R5 locked", {dn, gm}, 2'b10);
          chk(status == {4'hF, 2'(p), 2'b10}, "R5 keep", status, {4'hF, 2'(p), 2'b10});
          issue(4'b0001, 4'd0, 8'h00);
          chk(status[1] == 1'b0, "R4 wrdi", status[1], 0);
        end else begin
          chk(gm && !dn, "R5 open grant", {gm, dn}, 2'b10);
          ride_cycle(p, "R6 R4 write");
        end
      end
    end

    issue(4'b0010, 4'd0, 8'h00);
    issue(4'b0100, 4'd0, 8'h00);
    ride_cycle(0, "R7 restore");

    issue(4'b0010, 4'd0, 8'h00);
    @(negedge clk); wp_n = 0;
    @(negedge clk);
    chk(status[1] == 1'b0, "R4 wp clears", status[1], 0);
    issue(4'b0010, 4'd0, 8'h00);
    chk(status[1] == 1'b0, "R3 wren under wp", status[1], 0);
    issue(4'b1000, 4'd1, 8'h00);
    chk(dn && !gm, "R5 wp refuse", {dn, gm}, 2'b10);
    wp_n = 1;

    issue(4'b0010, 4'd0, 8'h00);
    issue(4'b1000, 4'd2, 8'h00);
    chk(gm, "R5 grant before busy", gm, 1);
    issue(4'b0001, 4'd0, 8'h00);
    chk(status[1:0] == 2'b11, "R9 wrdi ignored", status[1:0], 3);
    issue(4'b1000, 4'd3, 8'h00);
    chk(dn && !gm, "R5 busy refuse", {dn, gm}, 2'b10);
    repeat (WC) @(negedge clk);
    chk(status == 8'hF0, "R4 end clears", status, 8'hF0);

    issue(4'b0010, 4'd0, 8'h00);
    issue(4'b0100, 4'd0, 8'h08);
    chk(gs, "R8 setup", gs, 1);
    @(negedge clk); pwr_fail = 1;
    @(negedge clk); pwr_fail = 0;
    chk(status == 8'hF0, "R8 abort", status, 8'hF0);
    repeat (WC + 2) @(negedge clk);
    chk(status == 8'hF0, "R8 discarded", status, 8'hF0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule